// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block produces the serial clock of one master on a shared open-drain clock wire. It never drives the wire high. It either pulls the wire low or lets go of it, and it watches the real level of the wire through a synchronizer. The low phase lasts a programmable number of system clock cycles. The high phase is also timed by a programmable count, but that count starts only when the wire is seen to be high. A slower master that is still holding the wire low therefore stretches the low phase. A faster master that pulls the wire low early cuts the high phase short.

The transfer controller starts the clock with an enable input. It stops the clock at once with a yield input when arbitration is lost. The block gives out two one-cycle strobes. One marks the start of each timed high phase and is used to sample data. The other marks the start of each low phase and is used to change data.

Top module: `scl_clock_sync`

## Requirements
- R1: After reset and while `enable` is low, `scl_pull_low` is 0 and both strobes are 0.
- R2: When `enable` rises from idle, `scl_pull_low` goes to 1 in the cycle after the next clock edge. It stays at 1 for exactly `low_count` cycles. A start with `low_count` below 2 is a configuration error.
- R3: After its own low count ends, the block lets go of the wire. It holds in a wait phase, with no high count running, for as long as the synchronized wire reads low.
- R4: The high count starts only when the synchronized wire reads high. With no other master on the wire, each high level lasts `high_count + SYNC_STAGES + 1` cycles.
- R5: If another master holds the wire low longer than `low_count`, the low level on the wire lasts as long as that master holds it. The following high level keeps the length given in R4.
- R6: A falling edge on the synchronized wire during the high count ends the high phase early. It starts a full new low count.
- R7: `change_stb` is high for one cycle, the first cycle of every low phase, while the wire is being pulled low. `sample_stb` is high for one cycle, the first cycle of every timed high phase, while the wire is high. With no other master and a start from idle, `sample_stb` comes `low_count + SYNC_STAGES + 1` cycles after `change_stb`.
- R8: `yield_bus` drops `scl_pull_low` in the same cycle and stops both counters. When `yield_bus` clears with `enable` high, the block starts a fresh low phase of `low_count` cycles.
- R9: When `enable` falls, the block finishes the current low phase and one high phase. It then stays idle with the wire released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the serial clock; sampled at phase boundaries |
| yield_bus | input | 1 | Lets go of the wire at once and holds the block idle |
| low_count | input | CNT_W | Low phase length in system clock cycles (at least 2) |
| high_count | input | CNT_W | High phase length in cycles, counted from the sensed high level |
| scl_in | input | 1 | Actual level of the shared clock wire |
| scl_pull_low | output | 1 | 1 pulls the wire low; 0 leaves it released |
| sample_stb | output | 1 | One-cycle strobe at the start of each timed high phase |
| change_stb | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
Assertions check on every cycle that:
- a yield always lands the controller in idle on the next cycle;
- the wait phase never leaves while the sensed wire is low, and a timed high phase is entered only after the wire read high;
- a sensed fall during the high phase turns into a new low phase;
- each strobe agrees with the pull output.

Only the bench scenarios can show the lengths of the low and high levels on the wire. These lengths are measured with a modelled second master that either stretches the low level or cuts the high level short. The bench scenarios also cover recovery after a yield and the orderly stop after `enable` falls.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_line_sense.sv
// Brings the shared clock wire into the system clock domain and flags its
// falling edge.
module scl_line_sense #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_q,
   output logic line_fall
);
   localparam int LAST = STAGES - 1;

   initial assert (STAGES >= 2) else $error("scl_line_sense: STAGES must be at least 2");

   logic [STAGES-1:0] chain;
   logic              prev;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= line_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[LAST];
   end

   assign line_q    = chain[LAST];
   assign line_fall = prev & ~chain[LAST];
endmodule

// File: rtl/scl_phase_counter.sv
// Down counter for one phase. It is loaded at the start of a phase and
// flags its final cycle.
module scl_phase_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   input  logic          clear,
   output logic          last
);
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] ZERO = '0;

   initial assert (CW >= 2) else $error("scl_phase_counter: CW must be at least 2");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= ZERO;
      else if (clear)              cnt <= ZERO;
      else if (load)               cnt <= load_val;
      else if (run && cnt != ZERO) cnt <= cnt - ONE;
   end

   assign last = (cnt == ONE);
endmodule

// File: rtl/scl_phase_ctrl.sv
// Phase controller: timed low, wait for the wire to rise, timed high.
module scl_phase_ctrl
   import scl_sync_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          yield_bus,
   input  logic [CW-1:0] low_count,
   input  logic [CW-1:0] high_count,
   input  logic          line_q,
   input  logic          line_fall,
   input  logic          cnt_last,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_load_val,
   output logic          cnt_run,
   output logic          cnt_clear,
   output logic          pull_low,
   output logic          sample_stb,
   output logic          change_stb
);
   localparam logic [CW-1:0] MIN_COUNT = CW'(2);

   scl_phase_e st, st_nxt;
   logic       go_low, go_high;

   always_comb begin
      st_nxt       = st;
      cnt_load     = 1'b0;
      cnt_load_val = low_count;
      go_low       = 1'b0;
      go_high      = 1'b0;
      if (yield_bus) begin
         st_nxt = PH_IDLE;
      end else begin
         case (st)
            PH_IDLE: begin
               if (enable) begin
                  st_nxt   = PH_LOW;
                  cnt_load = 1'b1;
                  go_low   = 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt_last) st_nxt = PH_WAIT;
            end
            PH_WAIT: begin
               if (line_q) begin
                  st_nxt       = PH_HIGH;
                  cnt_load     = 1'b1;
                  cnt_load_val = high_count;
                  go_high      = 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt_last || line_fall) begin
                  if (enable) begin
                     st_nxt   = PH_LOW;
                     cnt_load = 1'b1;
                     go_low   = 1'b1;
                  end else begin
                     st_nxt = PH_IDLE;
                  end
               end
            end
            default: st_nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PH_IDLE;
         sample_stb <= 1'b0;
         change_stb <= 1'b0;
      end else begin
         st         <= st_nxt;
         sample_stb <= go_high;
         change_stb <= go_low;
      end
   end

   assign cnt_run   = ((st == PH_LOW) || (st == PH_HIGH)) && !yield_bus;
   assign cnt_clear = yield_bus;
   assign pull_low  = (st == PH_LOW) && !yield_bus;

   // R8
   yield_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      yield_bus |=> (st == PH_IDLE));

   // R3
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_WAIT && !line_q && !yield_bus) |=> (st == PH_WAIT));

   // R4
   high_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HIGH && $past(st) != PH_HIGH) |-> $past(line_q));

   // R6
   fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HIGH && line_fall && enable && !yield_bus) |=> (st == PH_LOW));

   // R2
   cfg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && enable && !yield_bus) |-> (low_count >= MIN_COUNT));
endmodule

// File: rtl/scl_clock_sync.sv
// Serial clock generator for a wire shared by several masters.
module scl_clock_sync #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             yield_bus,
   input  logic [CNT_W-1:0] low_count,
   input  logic [CNT_W-1:0] high_count,
   input  logic             scl_in,
   output logic             scl_pull_low,
   output logic             sample_stb,
   output logic             change_stb
);
   logic             line_q, line_fall;
   logic             cnt_load, cnt_run, cnt_clear, cnt_last;
   logic [CNT_W-1:0] cnt_load_val;

   scl_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_raw  (scl_in),
      .line_q    (line_q),
      .line_fall (line_fall)
   );

   scl_phase_counter #(.CW(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .run      (cnt_run),
      .clear    (cnt_clear),
      .last     (cnt_last)
   );

   scl_phase_ctrl #(.CW(CNT_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .yield_bus    (yield_bus),
      .low_count    (low_count),
      .high_count   (high_count),
      .line_q       (line_q),
      .line_fall    (line_fall),
      .cnt_last     (cnt_last),
      .cnt_load     (cnt_load),
      .cnt_load_val (cnt_load_val),
      .cnt_run      (cnt_run),
      .cnt_clear    (cnt_clear),
      .pull_low     (scl_pull_low),
      .sample_stb   (sample_stb),
      .change_stb   (change_stb)
   );

   // R7
   change_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (change_stb && !yield_bus) |-> scl_pull_low);

   // R7
   sample_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !scl_pull_low);
endmodule

// File: tb/scl_clock_sync_test.sv
`timescale 1ns/1ps
module scl_clock_sync_test;
   localparam int CW   = 8;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          yield_bus = 1'b0;
   logic [CW-1:0] low_count = 8'd4;
   logic [CW-1:0] high_count = 8'd5;
   logic          scl_pull_low, sample_stb, change_stb;
   logic          other_pull = 1'b0;
   logic          scl_bus;

   always #2.5 clk = ~clk;

   assign scl_bus = ~(scl_pull_low | other_pull);

   scl_clock_sync #(.CNT_W(CW), .SYNC_STAGES(SYNC)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .yield_bus    (yield_bus),
      .low_count    (low_count),
      .high_count   (high_count),
      .scl_in       (scl_bus),
      .scl_pull_low (scl_pull_low),
      .sample_stb   (sample_stb),
      .change_stb   (change_stb)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Second master on the wire. Mode 1 stretches every low level. Mode 2
   // pulls the wire low a short while after every rise.
   int   omode = 0;
   int   o_low_len = 0;
   int   o_high_wait = 0;
   int   o_lcnt = 0;
   int   o_hcnt = 0;
   logic o_prev = 1'b1;

   always @(posedge clk) begin
      o_prev <= scl_bus;
      if (o_lcnt > 0) begin
         if (o_lcnt == 1) other_pull <= 1'b0;
         o_lcnt <= o_lcnt - 1;
      end else if (omode == 1 && o_prev && !scl_bus) begin
         other_pull <= 1'b1;
         o_lcnt     <= o_low_len;
      end
      if (o_hcnt > 0) begin
         if (o_hcnt == 1) begin
            other_pull <= 1'b1;
            o_lcnt     <= o_low_len;
         end
         o_hcnt <= o_hcnt - 1;
      end else if (omode == 2 && !o_prev && scl_bus && o_lcnt == 0) begin
         o_hcnt <= o_high_wait;
      end
   end

   // Scoreboard of the levels on the wire: level, length in cycles, and the
   // requirement each one checks.
   typedef struct {
      logic  lvl;
      int    len;
      string req;
   } seg_t;
   seg_t q[$];

   task automatic expect_seg(input logic lvl, input int len, input string req);
      seg_t s;
      s.lvl = lvl;
      s.len = len;
      s.req = req;
      q.push_back(s);
   endtask

   logic m_lvl = 1'b1;
   int   m_len = 0;

   always @(negedge clk) begin
      seg_t s;
      if (rst_n) begin
         if (scl_bus === m_lvl) begin
            m_len++;
         end else begin
            if (q.size() > 0 && q[0].lvl == m_lvl) begin
               s = q.pop_front();
               check(m_len == s.len, s.req,
                     m_lvl ? "high level length" : "low level length", m_len, s.len);
            end
            m_lvl = scl_bus;
            m_len = 1;
         end
         // R7: each strobe agrees with the wire level
         if (sample_stb) check(scl_bus == 1'b1, "R7", "wire level at sample_stb", int'(scl_bus), 1);
         if (change_stb) check(scl_bus == 1'b0, "R7", "wire level at change_stb", int'(scl_bus), 0);
      end
   end

   task automatic wait_drain(input string req);
      int n = 0;
      while (q.size() > 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check(q.size() == 0, req, "scoreboard items left", q.size(), 0);
   endtask

   task automatic stop_all();
      @(negedge clk);
      yield_bus = 1'b1;
      enable    = 1'b0;
      omode     = 0;
      repeat (30) @(negedge clk);
      yield_bus = 1'b0;
      q.delete();
      repeat (4) @(negedge clk);
   endtask

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         errors++;
         $display("FAIL watchdog: run did not end actual=%0d expected=%0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      int bad;
      int seen;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(scl_pull_low == 1'b0, "R1", "pull in reset", int'(scl_pull_low), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sample_stb == 1'b0, "R1", "sample_stb after reset", int'(sample_stb), 0);
      check(change_stb == 1'b0, "R1", "change_stb after reset", int'(change_stb), 0);
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (scl_pull_low || sample_stb || change_stb) bad++;
      end
      check(bad == 0, "R1", "activity while disabled", bad, 0);

      // R2, R4, R7: alone on the wire, low 4, high 5
      low_count  = 8'd4;
      high_count = 8'd5;
      enable     = 1'b1;
      expect_seg(1'b0, 4, "R2");
      expect_seg(1'b1, 5 + SYNC + 1, "R4");
      expect_seg(1'b0, 4, "R2");
      expect_seg(1'b1, 5 + SYNC + 1, "R4");
      @(negedge clk);
      check(change_stb == 1'b1, "R7", "change_stb at first low cycle", int'(change_stb), 1);
      check(scl_pull_low == 1'b1, "R2", "pull after enable", int'(scl_pull_low), 1);
      n = 0;
      while (!sample_stb && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(n == 4 + SYNC + 1, "R7", "cycles from change_stb to sample_stb", n, 4 + SYNC + 1);
      @(negedge clk);
      check(sample_stb == 1'b0, "R7", "sample_stb width", int'(sample_stb), 0);
      wait_drain("R4");
      stop_all();

      // R5: other master holds the low level for 8 cycles
      omode     = 1;
      o_low_len = 8;
      enable    = 1'b1;
      expect_seg(1'b0, 9, "R5");
      expect_seg(1'b1, 5 + SYNC + 1, "R5");
      expect_seg(1'b0, 9, "R5");
      expect_seg(1'b1, 5 + SYNC + 1, "R5");
      wait_drain("R5");
      stop_all();

      // R6, R3: other master pulls low 3 cycles after each rise, for 6 cycles
      omode       = 2;
      o_high_wait = 3;
      o_low_len   = 6;
      enable      = 1'b1;
      expect_seg(1'b0, 4, "R2");
      expect_seg(1'b1, 4, "R6");
      expect_seg(1'b0, 7, "R6");
      expect_seg(1'b1, 4, "R6");
      expect_seg(1'b0, 7, "R3");
      wait_drain("R6");
      stop_all();

      // R2, R4: smallest counts
      low_count  = 8'd2;
      high_count = 8'd2;
      enable     = 1'b1;
      expect_seg(1'b0, 2, "R2");
      expect_seg(1'b1, 2 + SYNC + 1, "R4");
      expect_seg(1'b0, 2, "R2");
      expect_seg(1'b1, 2 + SYNC + 1, "R4");
      wait_drain("R4");
      stop_all();

      // R8: yield in the middle of a low phase
      low_count  = 8'd4;
      high_count = 8'd5;
      enable     = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(scl_pull_low == 1'b1, "R8", "pull before yield", int'(scl_pull_low), 1);
      yield_bus = 1'b1;
      #1;
      check(scl_pull_low == 1'b0, "R8", "pull in yield cycle", int'(scl_pull_low), 0);
      bad = 0;
      repeat (12) begin
         @(negedge clk);
         if (scl_pull_low || change_stb || sample_stb) bad++;
      end
      check(bad == 0, "R8", "activity during yield", bad, 0);
      q.delete();
      yield_bus = 1'b0;
      expect_seg(1'b0, 4, "R8");
      expect_seg(1'b1, 5 + SYNC + 1, "R8");
      @(negedge clk);
      check(scl_pull_low == 1'b1, "R8", "fresh low after yield", int'(scl_pull_low), 1);
      check(change_stb == 1'b1, "R8", "change_stb after yield", int'(change_stb), 1);
      wait_drain("R8");

      // R9: enable falls at the start of a low phase
      n = 0;
      while (!change_stb && n < 40) begin
         @(negedge clk);
         n++;
      end
      enable = 1'b0;
      q.delete();
      expect_seg(1'b0, 4, "R9");
      wait_drain("R9");
      bad  = 0;
      seen = 0;
      repeat (60) begin
         @(negedge clk);
         if (scl_pull_low || change_stb) bad++;
         if (sample_stb) seen++;
      end
      check(bad == 0, "R9", "pull or change_stb after stop", bad, 0);
      check(seen == 1, "R9", "high phases timed after stop", seen, 1);
      check(scl_bus == 1'b1, "R9", "wire level after stop", int'(scl_bus), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule